// File: doc/BRIEF.md
# Multi-Channel Countdown Timer Bank

A bank of up to eight independent down-counters sitting behind an APB slave port. Every channel has its own reload register, live count, control word and interrupt line. Once enabled, a channel subtracts one on each bus clock. When it passes zero it refills and flags an event. The timer clock is the bus clock.

Each channel has two reload behaviours. In free-running mode it refills with all ones. In user-defined mode it refills with its programmed reload value, which gives a periodic tick of reload+1 clocks.

Events are latched in a raw status bit. A channel's interrupt line is that raw bit gated by the channel's mask, so software can poll a masked channel through the raw status. Pending events are cleared by reading: either the channel's own acknowledge register or a shared register that acknowledges all channels. Transfers complete without wait states and never signal an error.

Top module: `apb_cdtimer_bank`

## Requirements
- R1: After reset every count and reload register reads 0, every control word reads 0x4 (disabled, masked), the raw and masked status read 0 and all interrupt lines are low.
- R2: A write to the control register (channel base + 0x08) that sets bit 0 (enable) while it was clear loads the count from the reload register (+0x00) on that same clock edge. Each later clock while enabled lowers the count by one.
- R3: With control bit 1 = 1 (user-defined), the clock after the count reaches 0 reloads the reload register value, so the count k edges after the enabling edge equals L - (k mod (L+1)).
- R4: With control bit 1 = 0 (free-running), the clock after the count reaches 0 loads 0xFFFFFFFF, whatever the reload register holds.
- R5: The current-value register (+0x04) returns the live count. Clearing enable freezes the count at the value reached on the disabling edge.
- R6: On every underflow the channel's raw bit (bit n of 0xA8) is set. Its interrupt line goes high only while control bit 2 (mask) is 0. Clearing the mask with an event pending raises the line.
- R7: A read of a channel's acknowledge register (+0x0C) clears only that channel's raw bit and returns 0. An underflow on the same edge keeps the bit set.
- R8: A read of 0xA0 clears the raw bits of all channels and returns 0.
- R9: 0xA4 returns raw AND NOT mask, one bit per channel. A channel's +0x10 returns its masked bit in bit 0.
- R10: 0xAC returns the VERSION parameter. Writes to read-only addresses change nothing. Unmapped addresses read 0.
- R11: PREADY is always 1 and PSLVERR always 0; every transfer finishes in its first access cycle.
- R12: Writing the reload register while a channel runs leaves the running count untouched; the new value is used at the next user-defined reload.

Channel n occupies the bytes from 0x14*n up to 0x14*n+0x13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and timer clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| irq_o | output | NUM_CH | Per-channel interrupt, raw status gated by mask |

## Verification
The countdown is run with a short user-defined reload of 5, a free-running channel loaded with 3, and a long reload of 100 that is rewritten while the channel runs. The 5 and 100 runs separate the periodic refill from the free-running refill to all ones. The mid-run rewrite shows whether the count or only the reload register is touched. The interrupt edge is sampled one clock before and one clock at the expected underflow, which exposes off-by-one periods. A masked channel, followed by unmasking with an event still pending, shows raw and masked status diverging. An acknowledge with two channels pending, followed by the shared clear, separates per-channel clearing from global clearing.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

   localparam int BUS_W     = 32;
   localparam int MAX_CH    = 8;
   localparam int CH_STRIDE = 20;

   localparam int OFS_LOAD  = 0;
   localparam int OFS_CUR   = 4;
   localparam int OFS_CTRL  = 8;
   localparam int OFS_ACK   = 12;
   localparam int OFS_ISTAT = 16;

   localparam int SH_CLRALL = 160;
   localparam int SH_MSTAT  = 164;
   localparam int SH_RAW    = 168;
   localparam int SH_VER    = 172;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_LOAD,
      SEL_CUR,
      SEL_CTRL,
      SEL_ACK,
      SEL_ISTAT,
      SEL_CLRALL,
      SEL_MSTAT,
      SEL_RAW,
      SEL_VER
   } sel_e;

   typedef struct packed {
      logic mask;
      logic mode;
      logic en;
   } ctrl_t;

   localparam ctrl_t CTRL_RST = '{mask: 1'b1, mode: 1'b0, en: 1'b0};

endpackage

// File: rtl/cdt_addr_decode.sv
module cdt_addr_decode
   import cdt_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output sel_e              sel,
   output logic [IDX_W-1:0]  ch
);

   always_comb begin
      int a;
      int off;
      a   = int'(addr);
      off = 0;
      sel = SEL_NONE;
      ch  = '0;
      if (a >= SH_CLRALL) begin
         case (a)
            SH_CLRALL: sel = SEL_CLRALL;
            SH_MSTAT:  sel = SEL_MSTAT;
            SH_RAW:    sel = SEL_RAW;
            SH_VER:    sel = SEL_VER;
            default:   sel = SEL_NONE;
         endcase
      end else begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (a >= i * CH_STRIDE && a < (i + 1) * CH_STRIDE) begin
               ch  = IDX_W'(i);
               off = a - i * CH_STRIDE;
               case (off)
                  OFS_LOAD:  sel = SEL_LOAD;
                  OFS_CUR:   sel = SEL_CUR;
                  OFS_CTRL:  sel = SEL_CTRL;
                  OFS_ACK:   sel = SEL_ACK;
                  OFS_ISTAT: sel = SEL_ISTAT;
                  default:   sel = SEL_NONE;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/cdt_channel.sv
module cdt_channel
   import cdt_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_load,
   input  logic             wr_ctrl,
   input  logic             clr,
   input  logic [CNT_W-1:0] wdata,
   input  ctrl_t            ctrl_in,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] load,
   output ctrl_t            ctrl,
   output logic             raw,
   output logic             irq
);

   logic             start;
   logic             at_zero;
   logic             uflow;
   logic [CNT_W-1:0] refill;

   assign start   = wr_ctrl & ctrl_in.en & ~ctrl.en;
   assign at_zero = (cnt == '0);
   assign uflow   = ctrl.en & at_zero;
   assign refill  = ctrl.mode ? load : {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= CTRL_RST;
         load <= '0;
      end else begin
         if (wr_ctrl) ctrl <= ctrl_in;
         if (wr_load) load <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (start) begin
         cnt <= load;
      end else if (ctrl.en) begin
         cnt <= at_zero ? refill : cnt - CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     raw <= 1'b0;
      else if (uflow) raw <= 1'b1;
      else if (clr)   raw <= 1'b0;
   end

   assign irq = raw & ~ctrl.mask;

endmodule

// File: rtl/cdt_rdata_mux.sv
module cdt_rdata_mux
   import cdt_pkg::*;
#(
   parameter int          NUM_CH  = 8,
   parameter int          CNT_W   = 32,
   parameter int          IDX_W   = 3,
   parameter logic [31:0] VERSION = 32'h0000_0215
) (
   input  sel_e                          sel,
   input  logic [IDX_W-1:0]              ch,
   input  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_a,
   input  logic [NUM_CH-1:0][CNT_W-1:0]  load_a,
   input  ctrl_t [NUM_CH-1:0]            ctrl_a,
   input  logic [NUM_CH-1:0]             raw_v,
   input  logic [NUM_CH-1:0]             mask_v,
   output logic [BUS_W-1:0]              rdata
);

   logic [NUM_CH-1:0] pend_v;

   assign pend_v = raw_v & ~mask_v;

   always_comb begin
      case (sel)
         SEL_LOAD:  rdata = BUS_W'(load_a[ch]);
         SEL_CUR:   rdata = BUS_W'(cnt_a[ch]);
         SEL_CTRL:  rdata = BUS_W'(ctrl_a[ch]);
         SEL_ISTAT: rdata = BUS_W'(pend_v[ch]);
         SEL_MSTAT: rdata = BUS_W'(pend_v);
         SEL_RAW:   rdata = BUS_W'(raw_v);
         SEL_VER:   rdata = VERSION;
         default:   rdata = '0;
      endcase
   end

endmodule

// File: rtl/apb_cdtimer_bank.sv
module apb_cdtimer_bank
   import cdt_pkg::*;
#(
   parameter int          NUM_CH  = 8,
   parameter int          CNT_W   = 32,
   parameter int          ADDR_W  = 8,
   parameter logic [31:0] VERSION = 32'h0000_0215
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   output logic              pready,
   output logic              pslverr,
   output logic [NUM_CH-1:0] irq_o
);

   localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_num_ch
      $error("NUM_CH must lie between 1 and 8");
   end
   if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_cnt_w
      $error("CNT_W must lie between 2 and 32");
   end
   if (ADDR_W < 8 || ADDR_W > 16) begin : g_bad_addr_w
      $error("ADDR_W must lie between 8 and 16");
   end

   logic                          acc;
   logic                          wr_acc;
   logic                          rd_acc;
   sel_e                          sel;
   logic [IDX_W-1:0]              ch_idx;
   logic [NUM_CH-1:0]             wr_load;
   logic [NUM_CH-1:0]             wr_ctrl;
   logic [NUM_CH-1:0]             clr;
   logic [NUM_CH-1:0][CNT_W-1:0]  cnt_a;
   logic [NUM_CH-1:0][CNT_W-1:0]  load_a;
   ctrl_t [NUM_CH-1:0]            ctrl_a;
   logic [NUM_CH-1:0]             raw_v;
   logic [NUM_CH-1:0]             en_v;
   logic [NUM_CH-1:0]             mode_v;
   logic [NUM_CH-1:0]             mask_v;
   ctrl_t                         ctrl_wr;

   assign acc     = psel & penable;
   assign wr_acc  = acc & pwrite;
   assign rd_acc  = acc & ~pwrite;
   assign ctrl_wr = ctrl_t'(pwdata[2:0]);

   cdt_addr_decode #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W)
   ) u_dec (
      .addr (paddr),
      .sel  (sel),
      .ch   (ch_idx)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit;
      assign hit        = (ch_idx == IDX_W'(i));
      assign wr_load[i] = wr_acc & hit & (sel == SEL_LOAD);
      assign wr_ctrl[i] = wr_acc & hit & (sel == SEL_CTRL);
      assign clr[i]     = rd_acc & ((hit & (sel == SEL_ACK)) | (sel == SEL_CLRALL));

      cdt_channel #(.CNT_W(CNT_W)) u_ch (
         .clk     (pclk),
         .rst_n   (presetn),
         .wr_load (wr_load[i]),
         .wr_ctrl (wr_ctrl[i]),
         .clr     (clr[i]),
         .wdata   (pwdata[CNT_W-1:0]),
         .ctrl_in (ctrl_wr),
         .cnt     (cnt_a[i]),
         .load    (load_a[i]),
         .ctrl    (ctrl_a[i]),
         .raw     (raw_v[i]),
         .irq     (irq_o[i])
      );

      assign en_v[i]   = ctrl_a[i].en;
      assign mode_v[i] = ctrl_a[i].mode;
      assign mask_v[i] = ctrl_a[i].mask;
   end

   cdt_rdata_mux #(
      .NUM_CH  (NUM_CH),
      .CNT_W   (CNT_W),
      .IDX_W   (IDX_W),
      .VERSION (VERSION)
   ) u_rmux (
      .sel    (sel),
      .ch     (ch_idx),
      .cnt_a  (cnt_a),
      .load_a (load_a),
      .ctrl_a (ctrl_a),
      .raw_v  (raw_v),
      .mask_v (mask_v),
      .rdata  (prdata)
   );

   assign pready  = 1'b1;
   assign pslverr = 1'b0;

endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
   parameter int NUM_CH = 8,
   parameter int CNT_W  = 32
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [NUM_CH-1:0]            en_v,
   input logic [NUM_CH-1:0]            mode_v,
   input logic [NUM_CH-1:0]            raw_v,
   input logic [NUM_CH-1:0][CNT_W-1:0] cnt_a,
   input logic [NUM_CH-1:0][CNT_W-1:0] ld_a
);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk

      // R5: a channel disabled across an edge keeps its count
      p_hold_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (!en_v[i] && !$past(en_v[i])) |-> $stable(cnt_a[i]));

      // R2: a running channel steps down by one
      p_step_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (en_v[i] && $past(en_v[i]) && $past(cnt_a[i]) != '0)
         |-> cnt_a[i] == $past(cnt_a[i]) - CNT_W'(1));

      // R3: user-defined refill takes the reload register
      p_user_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(en_v[i]) && $past(mode_v[i]) && $past(cnt_a[i]) == '0)
         |-> cnt_a[i] == $past(ld_a[i]));

      // R4: free-running refill is all ones
      p_free_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(en_v[i]) && !$past(mode_v[i]) && $past(cnt_a[i]) == '0)
         |-> cnt_a[i] == {CNT_W{1'b1}});

      // R6: an underflow always leaves the raw bit set
      p_uf_sets_raw_r6: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(en_v[i]) && $past(cnt_a[i]) == '0) |-> raw_v[i]);

      // R6: the raw bit rises only because of an underflow
      p_raw_rise_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(raw_v[i]) |-> ($past(en_v[i]) && $past(cnt_a[i]) == '0));
   end

endmodule

bind apb_cdtimer_bank cdt_checker #(
   .NUM_CH (NUM_CH),
   .CNT_W  (CNT_W)
) u_chk (
   .clk    (pclk),
   .rst_n  (presetn),
   .en_v   (en_v),
   .mode_v (mode_v),
   .raw_v  (raw_v),
   .cnt_a  (cnt_a),
   .ld_a   (load_a)
);

// File: tb/sim_apb_cdtimer_bank.sv
`timescale 1ns/1ps
module sim_apb_cdtimer_bank;

   localparam logic [31:0] VER = 32'h0000_0215;

   logic        clk = 1'b0;
   logic        presetn = 1'b0;
   logic        psel = 1'b0;
   logic        penable = 1'b0;
   logic        pwrite = 1'b0;
   logic [7:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready;
   logic        pslverr;
   logic [7:0]  irq_o;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   apb_cdtimer_bank #(.NUM_CH(8), .CNT_W(32), .ADDR_W(8), .VERSION(VER)) u0 (
      .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pslverr(pslverr), .irq_o(irq_o)
   );

   function automatic logic [7:0] ca(input int ch, input int ofs);
      return 8'(ch * 20 + ofs);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic apb_wr(input logic [7:0] a, input logic [31:0] d, output int c);
      @(negedge clk); paddr = a; pwdata = d; pwrite = 1'b1; psel = 1'b1; penable = 1'b0;
      @(negedge clk); penable = 1'b1;
      @(posedge clk); #1 c = cyc;
      @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic apb_rd(input logic [7:0] a, output logic [31:0] d, output int c);
      @(negedge clk); paddr = a; pwrite = 1'b0; psel = 1'b1; penable = 1'b0;
      @(negedge clk); penable = 1'b1;
      #1 d = prdata; c = cyc;
      @(posedge clk);
      @(negedge clk); psel = 1'b0; penable = 1'b0;
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] d; int c;
      chk(irq_o == 8'h00, "R1 irq after reset", 32'(irq_o), 0);
      chk(pready == 1'b1 && pslverr == 1'b0, "R11 ready/error", {30'b0, pready, pslverr}, 32'h2);
      apb_rd(ca(0, 8), d, c);  chk(d == 32'h4, "R1 ctrl ch0", d, 32'h4);
      apb_rd(ca(7, 8), d, c);  chk(d == 32'h4, "R1 ctrl ch7", d, 32'h4);
      apb_rd(ca(0, 4), d, c);  chk(d == 32'h0, "R1 count ch0", d, 0);
      apb_rd(ca(3, 0), d, c);  chk(d == 32'h0, "R1 reload ch3", d, 0);
      apb_rd(8'hA8, d, c);     chk(d == 32'h0, "R1 raw status", d, 0);
      apb_rd(8'hA4, d, c);     chk(d == 32'h0, "R1 masked status", d, 0);
   endtask

   task automatic t_user_period;
      logic [31:0] d, e; int c, c0, cd;
      apb_wr(ca(1, 0), 32'd5, c);
      apb_wr(ca(1, 8), 32'h3, c0);
      wait_until(c0 + 5);
      chk(irq_o[1] == 1'b0, "R3 no irq before period", 32'(irq_o[1]), 0);
      wait_until(c0 + 6);
      chk(irq_o[1] == 1'b1, "R3 irq at L+1", 32'(irq_o[1]), 1);
      apb_rd(ca(1, 4), d, c);
      e = 32'(5 - ((c - c0) % 6));
      chk(d == e, "R3 count after reload", d, e);
      apb_wr(ca(1, 8), 32'h2, cd);
      e = 32'(5 - ((cd - c0) % 6));
      apb_rd(ca(1, 4), d, c);  chk(d == e, "R5 frozen count", d, e);
      repeat (3) @(negedge clk);
      apb_rd(ca(1, 4), d, c);  chk(d == e, "R5 still frozen", d, e);
      apb_rd(ca(1, 12), d, c); chk(d == 0, "R7 ack reads zero", d, 0);
      apb_rd(8'hA8, d, c);     chk(d == 0, "R7 raw cleared", d, 0);
      chk(irq_o == 8'h00, "R7 irq low after ack", 32'(irq_o), 0);
   endtask

   task automatic t_free_run;
      logic [31:0] d, e; int c, c0, k;
      apb_wr(ca(2, 0), 32'd3, c);
      apb_wr(ca(2, 8), 32'h1, c0);
      wait_until(c0 + 3);
      chk(irq_o[2] == 1'b0, "R4 no irq before underflow", 32'(irq_o[2]), 0);
      wait_until(c0 + 4);
      chk(irq_o[2] == 1'b1, "R4 irq at underflow", 32'(irq_o[2]), 1);
      apb_rd(ca(2, 4), d, c);
      k = c - c0;
      e = 32'hFFFF_FFFF - 32'(k - 4);
      chk(d == e, "R4 refill with all ones", d, e);
      apb_wr(ca(2, 8), 32'h0, c);
      apb_rd(ca(2, 12), d, c);
   endtask

   task automatic t_mask;
      logic [31:0] d; int c, c0;
      apb_wr(ca(3, 0), 32'd2, c);
      apb_wr(ca(3, 8), 32'h5, c0);
      wait_until(c0 + 4);
      chk(irq_o[3] == 1'b0, "R6 masked irq stays low", 32'(irq_o[3]), 0);
      apb_rd(8'hA8, d, c);     chk(d == 32'h8, "R6 raw set while masked", d, 32'h8);
      apb_rd(8'hA4, d, c);     chk(d == 32'h0, "R9 masked status hides", d, 0);
      apb_rd(ca(3, 16), d, c); chk(d == 32'h0, "R9 channel status masked", d, 0);
      apb_wr(ca(3, 8), 32'h0, c);
      chk(irq_o[3] == 1'b1, "R6 unmask raises irq", 32'(irq_o[3]), 1);
      apb_rd(8'hA4, d, c);     chk(d == 32'h8, "R9 masked status shows", d, 32'h8);
      apb_rd(ca(3, 16), d, c); chk(d == 32'h1, "R9 channel status bit0", d, 1);
   endtask

   task automatic t_clear;
      logic [31:0] d; int c;
      apb_wr(ca(0, 0), 32'd1, c);
      apb_wr(ca(0, 8), 32'h1, c);
      apb_wr(ca(0, 8), 32'h0, c);
      apb_rd(8'hA8, d, c);     chk(d == 32'h9, "R6 two channels pending", d, 32'h9);
      apb_rd(ca(0, 12), d, c);
      apb_rd(8'hA8, d, c);     chk(d == 32'h8, "R7 ack clears only its channel", d, 32'h8);
      apb_rd(8'hA0, d, c);     chk(d == 32'h0, "R8 clear-all reads zero", d, 0);
      apb_rd(8'hA8, d, c);     chk(d == 32'h0, "R8 all raw cleared", d, 0);
      chk(irq_o == 8'h00, "R8 all irq low", 32'(irq_o), 0);
   endtask

   task automatic t_readonly;
      logic [31:0] d; int c;
      apb_rd(8'hAC, d, c);     chk(d == VER, "R10 version", d, VER);
      apb_wr(8'hAC, 32'h1234_5678, c);
      apb_rd(8'hAC, d, c);     chk(d == VER, "R10 version unchanged by write", d, VER);
      apb_wr(8'hA8, 32'hFFFF_FFFF, c);
      apb_rd(8'hA8, d, c);     chk(d == 0, "R10 raw unchanged by write", d, 0);
      apb_wr(ca(4, 4), 32'h1234, c);
      apb_rd(ca(4, 4), d, c);  chk(d == 0, "R10 count unchanged by write", d, 0);
      apb_rd(8'hB0, d, c);     chk(d == 0, "R10 unmapped reads zero", d, 0);
      chk(pready == 1'b1 && pslverr == 1'b0, "R11 ready/error later", {30'b0, pready, pslverr}, 32'h2);
   endtask

   task automatic t_reload_rewrite;
      logic [31:0] d, e; int c, c0;
      apb_wr(ca(5, 0), 32'd100, c);
      apb_wr(ca(5, 8), 32'h3, c0);
      apb_wr(ca(5, 0), 32'd7, c);
      apb_rd(ca(5, 4), d, c);
      e = 32'(100 - (c - c0));
      chk(d == e, "R12 running count untouched / R2 step", d, e);
      wait_until(c0 + 101);
      apb_rd(ca(5, 4), d, c);
      e = 32'(7 - (c - (c0 + 101)));
      chk(d == e, "R12 new reload used at refill", d, e);
      apb_wr(ca(5, 8), 32'h2, c);
      apb_rd(8'hA0, d, c);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      presetn = 1'b1;
      t_reset();
      t_user_period();
      t_free_run();
      t_mask();
      t_clear();
      t_readonly();
      t_reload_rewrite();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule